// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eight interrupt request lines toward a single CPU. Each line is captured on its rising edge into a pending set. A priority encoder picks the most urgent unmasked pending line and presents its index on the vector output. The CPU uses that index to find the service routine. Line 0 is the most urgent and line 7 the least.

The controller keeps an in-service set so that handlers can nest. A pending line raises the interrupt output only when it is strictly more urgent than every level now in service. Requests of equal or lower urgency wait. When the CPU acknowledges, the granted line leaves the pending set in that same clock edge and its in-service bit is set, so new requests are seen at once. An end-of-service pulse retires the most urgent active level, and control returns to the level that was preempted.

Top module: `nested_irq_ctrl`

## Requirements
- R1: After reset, the pending and in-service sets are empty, irq_o is 0 and vec_o is 0.
- R2: A 0-to-1 transition on req_i[k], seen between two clock edges, sets pending line k. A line held high does not set pending again until it falls and rises once more.
- R3: vec_o gives the lowest index among the unmasked pending lines. It is 0 when no unmasked line is pending.
- R4: irq_o is 1 exactly when an unmasked line is pending and either nothing is in service, or that line's index is lower than every in-service index.
- R5: If ack_i is 1 while irq_o is 1, the clock edge clears the pending bit of line vec_o and sets its in-service bit. If ack_i is 1 while irq_o is 0, the edge changes nothing.
- R6: If eos_i is 1, the clock edge clears the in-service bit with the lowest index. This returns service to the preempted level.
- R7: When mask_i[k] is 1, line k takes no part in irq_o or vec_o, but its pending bit is kept. Clearing the mask bit exposes the line again.
- R8: A new rising edge on a line whose level is already in service sets its pending bit again. The line is offered to the CPU only after its level has been retired.
- R9: While a level is in service, a request of equal or lower urgency keeps irq_o low. A more urgent request preempts that level. After the nested level retires, the waiting requests are offered in priority order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 8 | Request lines, one per device; a rising edge is captured |
| mask_i | input | 8 | Per-line block; 1 hides the line from arbitration |
| ack_i | input | 1 | CPU acknowledge of the offered vector |
| eos_i | input | 1 | CPU end-of-service for the most urgent active level |
| irq_o | output | 1 | Interrupt request to the CPU |
| vec_o | output | 3 | Index of the most urgent unmasked pending line |

## Verification
The hardest situation to reach is a stack three levels deep. In it, a line is re-requested while its own level is buried under a more urgent one, and then two end-of-service pulses must unwind the stack in the right order. A directed sequence builds exactly this stack: line 5 is granted, line 2 preempts it, line 5 rises again underneath, and then two levels are retired. A spurious acknowledge is checked afterwards through its effect on a later request. Randomized traffic with sparse acknowledges and retirements then follows. On every cycle of that traffic, irq_o and vec_o are compared with a reference model of the pending and in-service sets.

// File: rtl/nic_pkg.sv
package nic_pkg;
  localparam int unsigned NIC_LINES = 8;
  localparam int unsigned NIC_IDX_W = $clog2(NIC_LINES);
endpackage

// File: rtl/nic_prio_enc.sv
module nic_prio_enc #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o,
  output logic [N-1:0] onehot_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end

  assign any_o    = |vec_i;
  assign onehot_o = vec_i & (~vec_i + 1'b1);
endmodule

// File: rtl/nic_pend_latch.sv
module nic_pend_latch #(
  parameter int unsigned N = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  logic [N-1:0] req_q, pend_q, rise;

  assign rise = req_i & ~req_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q  <= '0;
      pend_q <= '0;
    end else begin
      req_q  <= req_i;
      pend_q <= (pend_q & ~clr_i) | rise;  // fresh edge wins over clear
    end
  end

  assign pend_o = pend_q;

  for (genvar k = 0; k < N; k++) begin : g_chk
    assert_latch_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rise[k] |=> pend_q[k]);
    assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[k] && !rise[k]) |=> !pend_q[k]);
  end
endmodule

// File: rtl/nic_in_service.sv
module nic_in_service #(
  parameter int unsigned N = 8,
  localparam int unsigned W = $clog2(N)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] set_i,
  input  logic         eos_i,
  output logic [N-1:0] isr_o,
  output logic         busy_o,
  output logic [W-1:0] top_idx_o
);
  logic [N-1:0] isr_q, top_oh;

  nic_prio_enc #(.N(N)) i_top_enc (
    .vec_i    (isr_q),
    .any_o    (busy_o),
    .idx_o    (top_idx_o),
    .onehot_o (top_oh)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) isr_q <= '0;
    else         isr_q <= (isr_q & ~(eos_i ? top_oh : '0)) | set_i;
  end

  assign isr_o = isr_q;

  assert_retire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eos_i && set_i == '0 && isr_q != '0)
      |=> $countones(isr_q) == $past($countones(isr_q)) - 1);
  assert_enter_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i != '0) |=> (isr_q & $past(set_i)) == $past(set_i));
endmodule

// File: rtl/nested_irq_ctrl.sv
module nested_irq_ctrl
  import nic_pkg::*;
#(
  parameter int unsigned N_LINES = NIC_LINES,
  localparam int unsigned IDX_W = $clog2(N_LINES)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] mask_i,
  input  logic               ack_i,
  input  logic               eos_i,
  output logic               irq_o,
  output logic [IDX_W-1:0]   vec_o
);
  logic [N_LINES-1:0] pend, eff, eff_oh, grant, isr;
  logic               eff_any, busy;
  logic [IDX_W-1:0]   isr_idx;

  nic_pend_latch #(.N(N_LINES)) i_pend (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .clr_i  (grant),
    .pend_o (pend)
  );

  assign eff = pend & ~mask_i;

  nic_prio_enc #(.N(N_LINES)) i_req_enc (
    .vec_i    (eff),
    .any_o    (eff_any),
    .idx_o    (vec_o),
    .onehot_o (eff_oh)
  );

  nic_in_service #(.N(N_LINES)) i_isr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .set_i     (grant),
    .eos_i     (eos_i),
    .isr_o     (isr),
    .busy_o    (busy),
    .top_idx_o (isr_idx)
  );

  // strictly more urgent than every active level
  assign irq_o = eff_any && (!busy || (vec_o < isr_idx));
  assign grant = (ack_i && irq_o) ? eff_oh : '0;

  assert_vec_pending_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eff_any |-> pend[vec_o]);
  assert_irq_unmasked_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !mask_i[vec_o]);
  assert_irq_outranks_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (isr & ((N_LINES'(1) << (vec_o + 1'b1)) - 1'b1)) == '0);
  assert_ack_ignored_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o && !eos_i) |=> $stable(isr));
endmodule

// File: tb/test_nested_irq_ctrl.sv
`timescale 1ns/1ps
module test_nested_irq_ctrl;
  localparam int N = 8;

  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic [N-1:0] req_i = '0, mask_i = '0;
  logic         ack_i = 1'b0, eos_i = 1'b0;
  logic         irq_o;
  logic [2:0]   vec_o;

  int checks = 0, errors = 0;
  logic [N-1:0] pend_m = '0, isr_m = '0, reqp_m = '0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  nested_irq_ctrl i_nested_irq_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .mask_i(mask_i),
    .ack_i(ack_i), .eos_i(eos_i), .irq_o(irq_o), .vec_o(vec_o)
  );

  function automatic int low_idx(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  function automatic logic exp_irq();
    int p, s;
    p = low_idx(pend_m & ~mask_i);
    s = low_idx(isr_m);
    return (p >= 0) && (s < 0 || p < s);
  endfunction

  function automatic int exp_vec();
    int p;
    p = low_idx(pend_m & ~mask_i);
    return (p < 0) ? 0 : p;
  endfunction

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_out(input logic irq, input int vec, input string tag);
    check(irq_o === irq, {tag, " irq"}, int'(irq_o), int'(irq));
    if (irq) check(int'(vec_o) == vec, {tag, " vec"}, int'(vec_o), vec);
  endtask

  // drive one cycle, update model at the edge, compare outputs after it
  task automatic cyc(input logic [N-1:0] req, input logic [N-1:0] msk,
                     input logic ack, input logic eos);
    logic [N-1:0] grant, retire;
    int v, s;
    req_i = req; mask_i = msk; ack_i = ack; eos_i = eos;
    #1;
    v = exp_vec();
    grant  = (ack && exp_irq()) ? (N'(1) << v) : '0;
    s = low_idx(isr_m);
    retire = (eos && s >= 0) ? (N'(1) << s) : '0;
    @(posedge clk_i);
    isr_m  = (isr_m & ~retire) | grant;
    pend_m = (pend_m & ~grant) | (req & ~reqp_m);
    reqp_m = req;
    #2;
    check(irq_o === exp_irq(), "R4 irq model", int'(irq_o), int'(exp_irq()));
    if (irq_o) check(int'(vec_o) == exp_vec(), "R3 vec model", int'(vec_o), exp_vec());
  endtask

  initial begin
    #4_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] r, m;
    void'($urandom(32'd4242));
    repeat (3) @(posedge clk_i);
    #3;
    check(irq_o === 1'b0, "R1 reset irq", int'(irq_o), 0);
    check(vec_o === 3'd0, "R1 reset vec", int'(vec_o), 0);
    rst_ni = 1'b1;
    @(posedge clk_i); #2;

    cyc(8'h20, 8'h00, 0, 0); expect_out(1, 5, "R2 edge latch");
    cyc(8'h20, 8'h00, 1, 0); expect_out(0, 0, "R5 ack clears, R2 held no relatch");
    cyc(8'h60, 8'h00, 0, 0); expect_out(0, 0, "R9 lower waits");
    cyc(8'h44, 8'h00, 0, 0); expect_out(1, 2, "R9 preempt");
    cyc(8'h44, 8'h00, 1, 0); expect_out(0, 0, "R5 grant nested");
    cyc(8'h64, 8'h00, 0, 0); expect_out(0, 0, "R8 relatch buried");
    cyc(8'h64, 8'h00, 0, 1); expect_out(0, 0, "R6 R8 equal waits");
    cyc(8'h64, 8'h00, 0, 1); expect_out(1, 5, "R6 unwind");
    cyc(8'h64, 8'h00, 1, 0); expect_out(0, 0, "R5 grant 5");
    cyc(8'h64, 8'h00, 0, 1); expect_out(1, 6, "R9 next in order");
    cyc(8'h64, 8'h40, 0, 0); expect_out(0, 0, "R7 masked");
    check(vec_o === 3'd0, "R7 masked vec", int'(vec_o), 0);
    cyc(8'h64, 8'h00, 0, 0); expect_out(1, 6, "R7 unmask keeps pending");
    cyc(8'h64, 8'h00, 1, 0); expect_out(0, 0, "R5 grant 6");
    cyc(8'h64, 8'h00, 1, 0); expect_out(0, 0, "R5 spurious ack");
    cyc(8'h64, 8'h00, 0, 1); expect_out(0, 0, "R6 retire 6");
    cyc(8'hE4, 8'h00, 0, 0); expect_out(1, 7, "R5 spurious ack ignored");
    cyc(8'h00, 8'h00, 1, 0); expect_out(0, 0, "R5 grant 7");
    cyc(8'h00, 8'h00, 0, 1); expect_out(0, 0, "R6 empty");

    for (int n = 0; n < 4000; n++) begin
      r = ($urandom % 4 == 0) ? N'($urandom) : req_i;
      m = ($urandom % 16 == 0) ? (N'($urandom) & N'($urandom)) : mask_i;
      cyc(r, m, ($urandom % 3) == 0, ($urandom % 5) == 0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule